// File: doc/BRIEF.md
# Page Write Staging and Write-Cycle Controller

This block stands between a two-wire serial slave engine and a 256-byte storage array organised as 32 pages of 8 bytes. The slave engine reports three events: a memory-address byte has arrived, a data byte has arrived, or a STOP was seen. With the STOP it reports the clock position within the 9-clock byte frame where the STOP happened. Data bytes are held in an 8-slot latch buffer. Each byte goes to the slot given by the low 3 bits of an internal address counter.

A STOP that lands in the clock slot right after an acknowledge commits the buffered bytes to the array and starts a timed write cycle. During that cycle `busy` is high, and the slave engine uses it to withhold acknowledges from every command. All event inputs are ignored while `busy` is high. A STOP in any other position throws the buffered bytes away. A write-protect input blocks every array write.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy` and `arr_we` are low, the buffer is empty and the address counter is 0, so a data byte sent with no address byte targets address 0x00.
- R2: An address-byte event loads the counter. Each data byte is stored in the buffer slot given by counter bits [2:0]. After each data byte the counter advances by one.
- R3: The counter advance wraps inside the page: bits [2:0] roll over from 7 to 0 and bits [7:3] do not change. If more than eight bytes arrive, the later bytes overwrite the slots they land on.
- R4: A STOP event with `stop_pos` equal to 1 (the first clock after the acknowledge clock) commits the buffer. A STOP with any other `stop_pos` value discards the buffered bytes, writes nothing and leaves `busy` low.
- R5: A commit writes only the slots filled since the last address byte or STOP. It writes one slot per clock, in ascending slot order, starting the clock after the STOP. Each write uses address {page, slot}, where page is counter bits [7:3].
- R6: `busy` rises the clock after a committing STOP and stays high for exactly WC_CYCLES clocks.
- R7: While `busy` is high, address, data and STOP events change neither the buffer nor the counter.
- R8: While `wp` is high, `arr_we` stays low. A commit still empties the buffer and still runs the full write cycle.
- R9: A STOP at position 1 with an empty buffer does not start a write cycle.
- R10: An address-byte event discards any bytes already in the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | One-clock strobe: memory-address byte received |
| addr_byte | input | 8 | Memory address carried with `addr_load` |
| data_stb | input | 1 | One-clock strobe: data byte received |
| data_byte | input | 8 | Data carried with `data_stb` |
| stop_evt | input | 1 | One-clock strobe: STOP condition seen |
| stop_pos | input | 4 | Clock position within the frame where the STOP occurred (1 = right after the acknowledge) |
| wp | input | 1 | Write protect, active high |
| busy | output | 1 | Write cycle in progress; the slave engine must refuse commands |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The main function is exercised with several kinds of transaction: a single byte written right after reset, a short run inside one page, a run that crosses the slot-7 boundary, and a ten-byte burst. The single byte after reset shows the counter starts at zero. The short run checks slot placement. The boundary run separates in-page wrap from carry into the page bits. The burst shows overwrite and ascending commit order. Further cases compare STOP positions 0, 1 and 5, a STOP with an empty buffer, an address byte arriving after data, write protect held high, and event strobes injected during the write cycle. Afterwards, a follow-up write shows that the counter was left unchanged.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int AW       = 8;
  localparam int SW       = 3;
  localparam int NSLOT    = 1 << SW;
  localparam int POS_W    = 4;
  localparam logic [POS_W-1:0] COMMIT_POS = 4'd1;

  // advance the address counter, wrapping inside the page
  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    logic [SW-1:0] lo;
    lo = p[SW-1:0] + 1'b1;
    return {p[AW-1:SW], lo};
  endfunction

  // index of the lowest set slot bit (0 when none)
  function automatic logic [SW-1:0] lowest_slot(input logic [NSLOT-1:0] m);
    logic [SW-1:0] r;
    r = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (m[i]) r = SW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
  import pgwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              addr_load,
  input  logic [AW-1:0]     addr_byte,
  input  logic              data_stb,
  input  logic [7:0]        data_byte,
  input  logic              discard,
  input  logic              clr_en,
  input  logic [SW-1:0]     clr_idx,
  input  logic [SW-1:0]     rd_idx,
  output logic [NSLOT-1:0]  mask,
  output logic [AW-SW-1:0]  page,
  output logic [7:0]        rd_data
);
  logic [AW-1:0] ptr;
  logic [7:0]    mem [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      mask <= '0;
      for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
    end else if (accept && addr_load) begin
      ptr  <= addr_byte;
      mask <= '0;
    end else if (accept && data_stb) begin
      mem[ptr[SW-1:0]]  <= data_byte;
      mask[ptr[SW-1:0]] <= 1'b1;
      ptr               <= next_ptr(ptr);
    end else if (discard) begin
      mask <= '0;
    end else if (clr_en) begin
      mask[clr_idx] <= 1'b0;
    end
  end

  assign page    = ptr[AW-1:SW];
  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
(
  input  logic             busy,
  input  logic             wp,
  input  logic [NSLOT-1:0] mask,
  output logic             pend,
  output logic             clr_en,
  output logic [SW-1:0]    idx,
  output logic             we
);
  always_comb begin
    pend   = |mask;
    idx    = lowest_slot(mask);
    clr_en = busy && pend;
    we     = busy && pend && !wp;
  end
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WC_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic pend,
  output logic busy
);
  localparam int CNT_W = $clog2(WC_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(WC_CYCLES - 1);
    end else if (busy) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      else if (!pend) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int WC_CYCLES = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_load,
  input  logic [AW-1:0]    addr_byte,
  input  logic             data_stb,
  input  logic [7:0]       data_byte,
  input  logic             stop_evt,
  input  logic [POS_W-1:0] stop_pos,
  input  logic             wp,
  output logic             busy,
  output logic             arr_we,
  output logic [AW-1:0]    arr_addr,
  output logic [7:0]       arr_wdata
);
  logic [NSLOT-1:0]  buf_mask;
  logic [AW-SW-1:0]  buf_page;
  logic [7:0]        buf_rd;
  logic              buf_pend;
  logic              clr_en;
  logic [SW-1:0]     slot_idx;
  logic              stop_seen;
  logic              commit_go;
  logic              drop_buf;

  // named events used by the bound checker
  assign stop_seen = stop_evt && !busy;
  assign commit_go = stop_seen && (stop_pos == COMMIT_POS) && buf_pend;
  assign drop_buf  = stop_seen && !commit_go;

  pgwr_buffer u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (!busy),
    .addr_load (addr_load),
    .addr_byte (addr_byte),
    .data_stb  (data_stb),
    .data_byte (data_byte),
    .discard   (drop_buf),
    .clr_en    (clr_en),
    .clr_idx   (slot_idx),
    .rd_idx    (slot_idx),
    .mask      (buf_mask),
    .page      (buf_page),
    .rd_data   (buf_rd)
  );

  pgwr_commit u_commit (
    .busy   (busy),
    .wp     (wp),
    .mask   (buf_mask),
    .pend   (buf_pend),
    .clr_en (clr_en),
    .idx    (slot_idx),
    .we     (arr_we)
  );

  pgwr_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (commit_go),
    .pend  (buf_pend),
    .busy  (busy)
  );

  assign arr_addr  = {buf_page, slot_idx};
  assign arr_wdata = buf_rd;
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_evt,
  input logic [3:0] stop_pos,
  input logic       wp,
  input logic       busy,
  input logic       arr_we,
  input logic [7:0] arr_addr,
  input logic       commit_go,
  input logic       buf_pend
);
  // R8: protect blocks every array write
  a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> !arr_we);

  // R5: array writes happen only inside the write cycle
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R5: back-to-back writes stay in one page and ascend by slot
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      (arr_addr[7:3] == $past(arr_addr[7:3])) && (arr_addr[2:0] > $past(arr_addr[2:0])));

  // R4: a misplaced STOP never starts a write cycle
  a_r4_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !busy && stop_pos != 4'd1) |=> !busy);

  // R6: busy only rises after a committing STOP
  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_go));

  // R9: STOP with nothing buffered leaves the block idle
  a_r9_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !busy && !buf_pend) |=> !busy);
endmodule

bind pgwr_ctrl pgwr_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_evt  (stop_evt),
  .stop_pos  (stop_pos),
  .wp        (wp),
  .busy      (busy),
  .arr_we    (arr_we),
  .arr_addr  (arr_addr),
  .commit_go (commit_go),
  .buf_pend  (buf_pend)
);

// File: tb/pgwr_ctrl_tb.sv
module pgwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WC         = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0;
  logic [7:0] addr_byte = '0;
  logic       data_stb = 1'b0;
  logic [7:0] data_byte = '0;
  logic       stop_evt = 1'b0;
  logic [3:0] stop_pos = '0;
  logic       wp = 1'b0;
  logic       busy, arr_we;
  logic [7:0] arr_addr, arr_wdata;

  int compared = 0;
  int mismatched = 0;

  // bench-side model
  logic [7:0]  m_ptr = '0;
  logic [7:0]  m_buf [8];
  logic [7:0]  m_mask = '0;
  logic [15:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwr_ctrl #(.WC_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_byte(addr_byte),
    .data_stb(data_stb), .data_byte(data_byte), .stop_evt(stop_evt),
    .stop_pos(stop_pos), .wp(wp), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every array write must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (exp_q.size() == 0) check("R5/R8 unexpected write", {arr_addr, arr_wdata}, 16'hxxxx);
      else check("R5 write", {arr_addr, arr_wdata}, exp_q.pop_front());
    end
  end

  task automatic send_addr(input logic [7:0] a);
    @(negedge clk); addr_load = 1'b1; addr_byte = a;
    @(negedge clk); addr_load = 1'b0;
    m_ptr = a; m_mask = '0;
  endtask

  task automatic send_data(input logic [7:0] d);
    @(negedge clk); data_stb = 1'b1; data_byte = d;
    @(negedge clk); data_stb = 1'b0;
    m_buf[m_ptr[2:0]] = d;
    m_mask[m_ptr[2:0]] = 1'b1;
    m_ptr = {m_ptr[7:3], m_ptr[2:0] + 3'd1};
  endtask

  // STOP with its position; noisy injects strobes during the write cycle (R7)
  task automatic send_stop(input logic [3:0] pos, input bit noisy, input string req);
    bit valid;
    int cnt;
    valid = (pos == 4'd1) && (m_mask != 0);
    if (valid && !wp)
      for (int s = 0; s < 8; s++)
        if (m_mask[s]) exp_q.push_back({m_ptr[7:3], 3'(s), m_buf[s]});
    m_mask = '0;
    @(negedge clk); stop_evt = 1'b1; stop_pos = pos;
    @(negedge clk); stop_evt = 1'b0;
    check({req, " busy after STOP"}, 16'(busy), 16'(valid));
    if (valid) begin
      cnt = 1;
      while (busy) begin
        @(negedge clk);
        addr_load = 1'b0; data_stb = 1'b0; stop_evt = 1'b0;
        if (noisy && cnt == 3) begin addr_load = 1'b1; addr_byte = 8'h77; end
        if (noisy && cnt == 4) begin data_stb = 1'b1; data_byte = 8'hEE; end
        if (noisy && cnt == 5) begin stop_evt = 1'b1; stop_pos = 4'd1; end
        if (busy) cnt++;
      end
      addr_load = 1'b0; data_stb = 1'b0; stop_evt = 1'b0;
      check("R6 busy length", 16'(cnt), 16'(WC));
    end else begin
      @(negedge clk);
      check({req, " stays idle"}, 16'(busy), 16'h0);
    end
    repeat (2) @(negedge clk);
    check({req, " queue drained"}, 16'(exp_q.size()), 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_buf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset busy", 16'(busy), 16'h0);
    check("R1 reset we", 16'(arr_we), 16'h0);

    // R1: counter starts at zero
    send_data(8'h5A);
    send_stop(4'd1, 1'b0, "R1");

    // R2: run inside one page
    send_addr(8'h13);
    send_data(8'hA1); send_data(8'hB2); send_data(8'hC3);
    send_stop(4'd1, 1'b0, "R2");

    // R3: wrap across slot 7 keeps the page
    send_addr(8'h2E);
    send_data(8'h01); send_data(8'h02); send_data(8'h03);
    send_stop(4'd1, 1'b0, "R3 wrap");

    // R3: ten bytes overwrite slots 0 and 1
    send_addr(8'h40);
    for (int i = 0; i < 10; i++) send_data(8'h10 + 8'(i));
    send_stop(4'd1, 1'b0, "R3 overwrite");

    // R4: misplaced STOPs discard
    send_addr(8'h50); send_data(8'h99);
    send_stop(4'd5, 1'b0, "R4 pos5");
    send_stop(4'd1, 1'b0, "R4 discarded then R9");
    send_addr(8'h51); send_data(8'h98);
    send_stop(4'd0, 1'b0, "R4 pos0");

    // R9: empty buffer
    send_stop(4'd1, 1'b0, "R9");

    // R10: address byte drops earlier data
    send_addr(8'h63); send_data(8'hAA);
    send_addr(8'h70); send_data(8'hBB);
    send_stop(4'd1, 1'b0, "R10");

    // R8: write protect
    wp = 1'b1;
    send_addr(8'h80); send_data(8'hC1); send_data(8'hC2);
    send_stop(4'd1, 1'b0, "R8 protected");
    wp = 1'b0;
    send_stop(4'd1, 1'b0, "R8 buffer emptied");

    // R7: strobes during the write cycle are ignored
    send_addr(8'h90); send_data(8'h11);
    send_stop(4'd1, 1'b1, "R7 noisy");
    send_stop(4'd1, 1'b0, "R7 buffer untouched");
    send_data(8'h22);
    send_stop(4'd1, 1'b0, "R7 counter untouched");

    check("R5 final queue", 16'(exp_q.size()), 16'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule